// File: doc/BRIEF.md
# Multi-bank outbound interrupt router

This block gathers a set of active-high level interrupt sources, captures each one in a sticky status bit, qualifies it with a per-source enable, and steers the qualified sources to a small set of destination interrupt lines. With the default parameters there are 86 sources grouped into three 32-bit banks (sources 0 to 31, 32 to 63 and 64 to 85) and nine destinations. Each destination line is the OR of every source that is pending, enabled and selected for that destination.

Software talks to the block through a single-cycle register port: an address, a write strobe, write data and combinational read data. Pending bits are acknowledged by writing ones to them. Enables are never written directly: one address per bank sets enable bits and another clears them, so two agents can change different enables without a read-modify-write race. Each destination owns one selection mask per bank, and a read-only identity word per bank shows which sources are currently driving that destination.

Top module: `irq_router`

## Requirements
- R1: After reset every pending, enable and selection bit is 0, every register reads 0 and all destination outputs are 0.
- R2: A pending bit is set at any clock edge where its source input is high; a pending bit of bank b, bit i reads at byte address 0x30+4b, bit i. When a source is high at the same edge as an acknowledge of its bit, the bit stays set.
- R3: Writing a word to 0x30+4b clears each pending bit of bank b whose data bit is 1 and leaves the others unchanged.
- R4: Writing a word to 0x60+4b sets each enable bit of bank b whose data bit is 1, leaving the others unchanged; enables of bank b read at 0x48+4b.
- R5: Writing a word to 0x54+4b clears each enable bit of bank b whose data bit is 1, leaving the others unchanged.
- R6: The selection mask of destination d for bank b is read/write at 0x78+0x24b+4d (d = 0..8); writing one mask changes no other.
- R7: The identity word of destination d for bank b reads at 0xE4+0x24b+4d and equals pending AND enable AND that selection mask; writes to it have no effect.
- R8: Destination output d is high one clock edge after any of its identity bits in any bank is set, and falls one edge after the last one clears.
- R9: Bits 22 to 31 of bank 2 (sources 86 to 95) read as 0 in every register and ignore writes.
- R10: A read of any address not listed above returns 0, and a write there changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 86 | Level-high interrupt sources |
| addr_i | input | 9 | Byte address of the register access |
| wr_i | input | 1 | Write strobe, acts at the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| dst_o | output | 9 | Destination interrupt lines |

## Verification
A source high before edge k is visible in its pending and identity reads right after edge k, and the matching destination line moves only after edge k+1; register writes behave the same way, with the new register value readable just after the write edge and the line following one edge later. The directed tasks drive inputs on the falling edge and sample read data and outputs one time unit after the next falling edge, checking the destination line both before and after that extra edge so a missing or extra register stage is caught. Boundary cases cover the acknowledge-versus-source collision, the unused top bits of the last bank and holes in the address map.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int N_SRC = 86,
  parameter int N_DST = 9,
  parameter int W     = 32,
  parameter int AW    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic [N_DST-1:0]  dst_o
);
  localparam int NB         = (N_SRC + W - 1) / W;
  localparam int TOT        = NB * W;
  localparam int PEND_OFS   = 'h30;
  localparam int ENA_OFS    = 'h48;
  localparam int CLR_OFS    = 'h54;
  localparam int SET_OFS    = 'h60;
  localparam int SEL_OFS    = 'h78;
  localparam int IDN_OFS    = SEL_OFS + NB * N_DST * 4;
  localparam logic [TOT-1:0] LIVE = {{(TOT-N_SRC){1'b0}}, {N_SRC{1'b1}}};

  logic [TOT-1:0]   pend_q, pend_d, ena_q, ena_d, src_w;
  logic [TOT-1:0]   sel_q [N_DST];
  logic [TOT-1:0]   sel_d [N_DST];
  logic [N_DST-1:0] dst_q, dst_d;

  assign src_w = {{(TOT-N_SRC){1'b0}}, src_i};
  assign dst_o = dst_q;

  function automatic logic hit(input logic [AW-1:0] a, input int ofs);
    return a == AW'(ofs);
  endfunction

  always_comb begin
    pend_d  = pend_q;
    ena_d   = ena_q;
    sel_d   = sel_q;
    rdata_o = '0;
    for (int b = 0; b < NB; b++) begin
      if (hit(addr_i, PEND_OFS + 4*b)) rdata_o = pend_q[b*W +: W];
      if (hit(addr_i, ENA_OFS + 4*b))  rdata_o = ena_q[b*W +: W];
      if (wr_i && hit(addr_i, PEND_OFS + 4*b))
        pend_d[b*W +: W] = pend_q[b*W +: W] & ~wdata_i;
      if (wr_i && hit(addr_i, SET_OFS + 4*b))
        ena_d[b*W +: W] = ena_d[b*W +: W] | wdata_i;
      if (wr_i && hit(addr_i, CLR_OFS + 4*b))
        ena_d[b*W +: W] = ena_d[b*W +: W] & ~wdata_i;
      for (int d = 0; d < N_DST; d++) begin
        if (hit(addr_i, SEL_OFS + (b*N_DST + d)*4)) begin
          rdata_o = sel_q[d][b*W +: W];
          if (wr_i) sel_d[d][b*W +: W] = wdata_i;
        end
        if (hit(addr_i, IDN_OFS + (b*N_DST + d)*4))
          rdata_o = pend_q[b*W +: W] & ena_q[b*W +: W] & sel_q[d][b*W +: W];
      end
    end
    pend_d = (pend_d | src_w) & LIVE;
    ena_d  = ena_d & LIVE;
    for (int d = 0; d < N_DST; d++) begin
      sel_d[d] = sel_d[d] & LIVE;
      dst_d[d] = |(pend_q & ena_q & sel_q[d]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ena_q  <= '0;
      dst_q  <= '0;
      for (int d = 0; d < N_DST; d++) sel_q[d] <= '0;
    end else begin
      pend_q <= pend_d;
      ena_q  <= ena_d;
      dst_q  <= dst_d;
      for (int d = 0; d < N_DST; d++) sel_q[d] <= sel_d[d];
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int N_SRC = 86,
  parameter int N_DST = 9,
  parameter int W     = 32,
  parameter int AW    = 9
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic [N_SRC-1:0]                       src_i,
  input logic [AW-1:0]                          addr_i,
  input logic                                   wr_i,
  input logic [W-1:0]                           rdata_o,
  input logic [N_DST-1:0]                       dst_o,
  input logic [((N_SRC+W-1)/W)*W-1:0]           pend_q,
  input logic [((N_SRC+W-1)/W)*W-1:0]           ena_q,
  input logic [((N_SRC+W-1)/W)*W-1:0]           sel_q [N_DST]
);
  localparam int NB  = (N_SRC + W - 1) / W;
  localparam int TOT = NB * W;
  localparam int END = 'h78 + 2 * NB * N_DST * 4;

  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  AST_SRC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> ((pend_q[N_SRC-1:0] & $past(src_i)) == $past(src_i))); // R2

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[TOT-1:N_SRC] == '0) && (ena_q[TOT-1:N_SRC] == '0)); // R9

  AST_ENA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ena_q)); // R4

  AST_HOLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr_i) >= END || int'(addr_i) < 'h30) |-> (rdata_o == '0)); // R10

  for (genvar d = 0; d < N_DST; d++) begin : g_dst
    AST_DST_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      seen |=> (dst_o[d] == $past(|(pend_q & ena_q & sel_q[d])))); // R8
  end
endmodule

bind irq_router irq_router_chk #(.N_SRC(N_SRC), .N_DST(N_DST), .W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .addr_i(addr_i), .wr_i(wr_i),
  .rdata_o(rdata_o), .dst_o(dst_o), .pend_q(pend_q), .ena_q(ena_q), .sel_q(sel_q)
);

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [85:0] src = '0;
  logic [8:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [8:0]  dst;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  irq_router u0 (.clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr), .wr_i(wr),
                 .wdata_i(wdata), .rdata_o(rdata), .dst_o(dst));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk); addr = 9'(a); wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    addr = 9'(a); #1; d = rdata; addr = '0;
  endtask

  task automatic pulse_src(input int k);
    @(negedge clk); src[k] = 1'b1;
    @(negedge clk); src[k] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd_reg('h30, v); check("R1 pending0", v, 0);
    rd_reg('h50, v); check("R1 enable2", v, 0);
    rd_reg('hAC, v); check("R1 select", v, 0);
    check("R1 dst", {23'd0, dst}, 0);
  endtask

  task automatic t_pending;
    logic [31:0] v;
    pulse_src(5); #1;
    rd_reg('h30, v); check("R2 bank0 bit5", v, 32'h20);
    pulse_src(40); #1;
    rd_reg('h34, v); check("R2 bank1 bit8", v, 32'h100);
    wr_reg('h30, 32'h20); #1;
    rd_reg('h30, v); check("R3 ack bank0", v, 0);
    rd_reg('h34, v); check("R3 other bank kept", v, 32'h100);
    @(negedge clk); src[3] = 1'b1; addr = 9'h30; wdata = 32'h8; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = '0; src[3] = 1'b0; #1;
    rd_reg('h30, v); check("R2 set beats ack", v, 32'h8);
    wr_reg('h30, 32'h8); wr_reg('h34, 32'hFFFF_FFFF); #1;
    rd_reg('h30, v); check("R3 ack after release", v, 0);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    wr_reg('h60, 32'hF0); #1;
    rd_reg('h48, v); check("R4 set", v, 32'hF0);
    wr_reg('h60, 32'h0F); #1;
    rd_reg('h48, v); check("R4 set keeps others", v, 32'hFF);
    wr_reg('h54, 32'h3C); #1;
    rd_reg('h48, v); check("R5 clear", v, 32'hC3);
    wr_reg('h54, 32'hFFFF_FFFF); #1;
    rd_reg('h48, v); check("R5 clear all", v, 0);
  endtask

  task automatic t_select;
    logic [31:0] v;
    wr_reg('hAC, 32'hDEAD_BEEF); #1;
    rd_reg('hAC, v); check("R6 bank1 dst4", v, 32'hDEAD_BEEF);
    rd_reg('hA8, v); check("R6 neighbour", v, 0);
    rd_reg('h78, v); check("R6 bank0 dst0", v, 0);
    wr_reg('hAC, 0);
  endtask

  task automatic t_route;
    logic [31:0] v;
    wr_reg('h68, 32'h40);
    wr_reg('hE0, 32'h40);
    @(negedge clk); src[70] = 1'b1;
    @(negedge clk); src[70] = 1'b0; #1;
    rd_reg('h14C, v); check("R7 ident bank2 dst8", v, 32'h40);
    rd_reg('h128, v); check("R7 ident other dst", v, 0);
    check("R8 not yet", {23'd0, dst}, 0);
    @(negedge clk); #1;
    check("R8 raised", {23'd0, dst}, 32'h100);
    wr_reg('h14C, 0); #1;
    rd_reg('h14C, v); check("R7 ident read-only", v, 32'h40);
    wr_reg('h38, 32'h40); #1;
    check("R8 held one edge", {23'd0, dst}, 32'h100);
    @(negedge clk); #1;
    check("R8 dropped", {23'd0, dst}, 0);
    wr_reg('h5C, 32'hFFFF_FFFF); wr_reg('hE0, 0);
  endtask

  task automatic t_pad;
    logic [31:0] v;
    wr_reg('h68, 32'hFFFF_FFFF); #1;
    rd_reg('h50, v); check("R9 enable2 pad", v, 32'h003F_FFFF);
    wr_reg('hC0, 32'hFFFF_FFFF); #1;
    rd_reg('hC0, v); check("R9 select2 pad", v, 32'h003F_FFFF);
    wr_reg('h5C, 32'hFFFF_FFFF); wr_reg('hC0, 0);
  endtask

  task automatic t_hole;
    logic [31:0] v;
    wr_reg('h60, 32'h1);
    rd_reg('h3C, v); check("R10 hole 0x3C", v, 0);
    rd_reg('h00, v); check("R10 hole 0x00", v, 0);
    rd_reg('h150, v); check("R10 past end", v, 0);
    rd_reg('h74, v); check("R10 hole 0x74", v, 0);
    wr_reg('h3C, 32'hFFFF_FFFF); wr_reg('h6C, 32'hFFFF_FFFF); #1;
    rd_reg('h48, v); check("R10 write to hole", v, 32'h1);
    rd_reg('h4C, v); check("R10 write to hole bank1", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_pending(); t_enable(); t_select(); t_route(); t_pad(); t_hole();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200us;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule